// File: doc/BRIEF.md
# Three-Word Maskable Interrupt Collector

The block gathers 96 level-sensitive interrupt requests, grouped as three 32-bit words, into a single interrupt line for a processor. Each source can be blocked by a mask bit. Software changes the mask bits only through two dedicated write ports per word: one that sets chosen bits and one that clears chosen bits. This lets a handler enable or disable one source without a read-modify-write. The raw request levels and the current mask can both be read back.

Two helpers come alongside the register file. The first is a priority picker that reports which vector should be serviced next. It scans the highest word first and, inside a word, starts from the lowest bit. The second is a decoder that turns a packed 12-bit interrupt identifier into a word index, a bit index and a flat vector number, so software can address a source by its identifier.

Register map: word `w` sits at byte base `0x10*w`. Inside a word, the raw status is at `+0x0`, the mask status at `+0x4`, the mask-set port at `+0x8` and the mask-clear port at `+0xC`.

Top module: `irq_collector`

## Requirements
- R1: After reset every mask bit is 1, so all sources start disabled. In that state `irq_o` is 0 and the mask status of every word reads `0xFFFFFFFF`.
- R2: A read at offset `0x0` of word `w` returns the current levels of `src_i[32*w+31 : 32*w]`.
- R3: Writing to offset `0x8` of a word sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value. The new mask is visible from the next clock.
- R4: Writing to offset `0xC` of a word clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R5: A write to offset `0x0` or `0x4`, to word index 3 (base `0x30`), or to an address with `bus_addr[1:0]` not equal to 0 changes no mask bit. Reads at such unmapped addresses return 0.
- R6: A source is pending when its status bit is 1 and its mask bit is 0. `irq_o` is registered: it equals the OR of all 96 pending bits as they stood one clock earlier.
- R7: `next_vec_o` gives the pending vector with the highest priority, computed as `32*word + bit`. Word 2 is checked first, then word 1, then word 0. Inside a word, bit 0 comes before bit 31. `next_valid_o` is 1 while any source is pending.
- R8: When nothing is pending, `next_valid_o` is 0 and `next_vec_o` is 0.
- R9: The identifier decoder gives the bit index as `id_i[4:0]`. It computes a raw word number as `id_i[11:9] | id_i[7:5]`. A raw value of 0 selects word 0, a value of 1 selects word 1 and any larger value selects word 2. The flat vector is `32*word + bit`.
- R10: A read at offset `0x4`, `0x8` or `0xC` of a word returns that word's current mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 96 | Level interrupt requests, vector n on bit n |
| bus_addr | input | 6 | Byte address of register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Registered processor interrupt line |
| next_vec_o | output | 7 | Highest-priority pending vector |
| next_valid_o | output | 1 | Some source is pending |
| id_i | input | 12 | Packed interrupt identifier |
| id_word_o | output | 2 | Decoded word index (0 to 2) |
| id_bit_o | output | 5 | Decoded bit index |
| id_flat_o | output | 7 | Decoded flat vector number |

## Verification
The hardest situation to reach is a contest between words: the picker must let a low bit of word 2 win over a pending source in word 1. It must also fall back correctly once word 2 goes quiet. The stimulus reaches this by first using the clear port to unmask chosen bits in two words. It then raises requests in both words and checks the winner, then drops the word 2 requests and checks the fallback. The registered interrupt line is checked on both sides of its one-cycle delay. This is done by sampling right after an input change and again after the next edge.

// File: rtl/irqc_pkg.sv
// Package: shared sizes and register offsets for the interrupt collector.
// Assumes byte addressing with 32-bit registers and 16-byte word blocks.
package irqc_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 3;
    localparam int NUM_SRC   = WORD_W * NUM_WORDS;
    localparam int VEC_W     = $clog2(NUM_SRC);
    localparam int BIT_W     = $clog2(WORD_W);
    localparam int WSEL_W    = 2;
    localparam int ADDR_W    = WSEL_W + 4;
    localparam int ID_W      = 12;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_MSTAT  = 2'd1,
        REG_MSET   = 2'd2,
        REG_MCLR   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irqc_word.sv
// Module: one 32-bit word of mask state.
// Updates the mask through separate set and clear strobes and produces the
// pending vector. Assumes at most one of the two strobes is high per cycle.
module irqc_word
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] src_i,
    input  logic              wr_set_i,
    input  logic              wr_clr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] mask_o,
    output logic [WORD_W-1:0] pend_o
);
    logic [WORD_W-1:0] mask_q;

    // Mask register: reset to all-disabled, then write-one-to-set or write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr_set_i)
            mask_q <= mask_q | wdata_i;
        else if (wr_clr_i)
            mask_q <= mask_q & ~wdata_i;
    end

    // A source is pending when it is requesting and not blocked.
    always_comb pend_o = src_i & ~mask_q;

    assign mask_o = mask_q;

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)) &&
                     (((mask_q ^ $past(mask_q)) & ~$past(wdata_i)) == '0));

    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr_i && !wr_set_i) |=> ((mask_q & $past(wdata_i)) == '0) &&
                     (((mask_q ^ $past(mask_q)) & ~$past(wdata_i)) == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set_i && !wr_clr_i) |=> $stable(mask_q));
endmodule

// File: rtl/irqc_pick.sv
// Module: next-vector priority picker.
// The highest word with a pending bit wins. Inside that word the lowest bit
// wins. Purely combinational; reports 0 when nothing is pending.
module irqc_pick
    import irqc_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [VEC_W-1:0]   vec_o,
    output logic               valid_o
);
    // Scan upward over words so a higher word overrides; scan bits downward so the lowest bit is last.
    always_comb begin
        vec_o   = '0;
        valid_o = 1'b0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (|pend_i[w*WORD_W +: WORD_W]) begin
                valid_o = 1'b1;
                for (int b = WORD_W - 1; b >= 0; b--) begin
                    if (pend_i[w*WORD_W + b])
                        vec_o = VEC_W'(w*WORD_W + b);
                end
            end
        end
    end

    // R7: a reported vector is always in range and is really pending.
    always_comb begin
        if (valid_o) begin
            p_vec_pending_r7: assert (pend_i[vec_o]);
        end
        else begin
            p_idle_zero_r8: assert (vec_o == '0 && pend_i == '0);
        end
    end
endmodule

// File: rtl/irqc_id_split.sv
// Module: packed identifier decoder.
// Bit index comes from the low five bits. The word number is the OR of two
// three-bit fields, clamped to the last word. Combinational.
module irqc_id_split
    import irqc_pkg::*;
(
    input  logic [ID_W-1:0]   id_i,
    output logic [WSEL_W-1:0] word_o,
    output logic [BIT_W-1:0]  bit_o,
    output logic [VEC_W-1:0]  flat_o
);
    logic [2:0] raw_word;
    logic       id_unused;

    assign id_unused = id_i[8];

    // Merge the two word fields, then clamp to the implemented word range.
    always_comb begin
        raw_word = id_i[11:9] | id_i[7:5];
        bit_o    = id_i[BIT_W-1:0];
        if (raw_word > 3'(NUM_WORDS - 1))
            word_o = WSEL_W'(NUM_WORDS - 1);
        else
            word_o = raw_word[WSEL_W-1:0];
        flat_o = VEC_W'(word_o) * VEC_W'(WORD_W) + VEC_W'(bit_o);
    end

    always_comb begin
        p_word_clamp_r9: assert (word_o < WSEL_W'(NUM_WORDS));
    end
endmodule

// File: rtl/irq_collector.sv
// Module: top of the three-word interrupt collector.
// Decodes a simple register bus onto per-word mask logic, drives the
// registered interrupt line and exposes the picker and identifier decoder.
// Assumes one-cycle write strobes and a combinational read path.
module irq_collector
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic [VEC_W-1:0]   next_vec_o,
    output logic               next_valid_o,
    input  logic [ID_W-1:0]    id_i,
    output logic [WSEL_W-1:0]  id_word_o,
    output logic [BIT_W-1:0]   id_bit_o,
    output logic [VEC_W-1:0]   id_flat_o
);
    logic [WSEL_W-1:0]  wsel;
    reg_sel_e           rsel;
    logic               aligned;
    logic [NUM_SRC-1:0] mask_all;
    logic [NUM_SRC-1:0] pend_all;
    logic               irq_q;

    assign wsel    = bus_addr[ADDR_W-1:4];
    assign rsel    = reg_sel_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit;
        assign hit = bus_wr && aligned && (wsel == WSEL_W'(w));
        irqc_word u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_i    (src_i[w*WORD_W +: WORD_W]),
            .wr_set_i (hit && rsel == REG_MSET),
            .wr_clr_i (hit && rsel == REG_MCLR),
            .wdata_i  (bus_wdata),
            .mask_o   (mask_all[w*WORD_W +: WORD_W]),
            .pend_o   (pend_all[w*WORD_W +: WORD_W])
        );
    end

    // Read mux: raw levels at status, mask bits at the other three offsets.
    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (aligned && wsel == WSEL_W'(w)) begin
                if (rsel == REG_STATUS)
                    bus_rdata = src_i[w*WORD_W +: WORD_W];
                else
                    bus_rdata = mask_all[w*WORD_W +: WORD_W];
            end
        end
    end

    // Interrupt line: registered OR of every pending source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |pend_all;
    end

    assign irq_o = irq_q;

    irqc_pick u_pick (
        .pend_i  (pend_all),
        .vec_o   (next_vec_o),
        .valid_o (next_valid_o)
    );

    irqc_id_split u_id (
        .id_i   (id_i),
        .word_o (id_word_o),
        .bit_o  (id_bit_o),
        .flat_o (id_flat_o)
    );

    p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(next_valid_o)));

    p_reset_masked_r1: assert property (@(posedge clk)
        !rst_n |=> (mask_all == '1 && !irq_o));
endmodule

// File: tb/sim_irq_collector.sv
module sim_irq_collector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = '0;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [6:0]  nvec;
    logic        nvalid;
    logic [11:0] id = '0;
    logic [1:0]  id_word;
    logic [4:0]  id_bit;
    logic [6:0]  id_flat;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] mask_m [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_collector u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .next_vec_o(nvec),
        .next_valid_o(nvalid), .id_i(id), .id_word_o(id_word), .id_bit_o(id_bit),
        .id_flat_o(id_flat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    // Expected picker result, derived from the priority rule of R7/R8.
    function automatic logic [7:0] exp_pick();
        for (int w = 2; w >= 0; w--)
            for (int b = 0; b < 32; b++)
                if (src[w*32+b] && !mask_m[w][b])
                    return {1'b1, 7'(w*32+b)};
        return 8'h00;
    endfunction

    task automatic pick_chk(input string req);
        logic [7:0] e;
        #1;
        e = exp_pick();
        check({req, " valid"}, {31'd0, nvalid}, {31'd0, e[7]});
        check({req, " vec"}, {25'd0, nvec}, {25'd0, e[6:0]});
    endtask

    task automatic t_reset();
        for (int w = 0; w < 3; w++) mask_m[w] = '1;
        @(negedge clk);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        for (int w = 0; w < 3; w++) read_chk("R1 mask status reset", 6'(16*w + 4), 32'hFFFF_FFFF);
        pick_chk("R8 idle");
    endtask

    task automatic t_status();
        src = {32'hA5A5_0001, 32'h0000_8000, 32'h1234_5678};
        read_chk("R2 status word0", 6'h00, 32'h1234_5678);
        read_chk("R2 status word1", 6'h10, 32'h0000_8000);
        read_chk("R2 status word2", 6'h20, 32'hA5A5_0001);
        @(negedge clk);
        check("R6 masked sources give no irq", {31'd0, irq}, 32'd0);
        pick_chk("R8 all masked");
        src = '0;
    endtask

    task automatic t_clear_set();
        bus_write(6'h0C, 32'h0000_0011);
        mask_m[0] = 32'hFFFF_FFEE;
        read_chk("R4 mask after clear", 6'h04, 32'hFFFF_FFEE);
        read_chk("R10 read at set port", 6'h08, 32'hFFFF_FFEE);
        read_chk("R10 read at clear port", 6'h0C, 32'hFFFF_FFEE);
        src[0] = 1'b1; src[4] = 1'b1;
        pick_chk("R7 lowest bit first");
        @(negedge clk);
        check("R6 irq one clock later", {31'd0, irq}, 32'd1);
        bus_write(6'h08, 32'h0000_0001);
        mask_m[0] = 32'hFFFF_FFEF;
        read_chk("R3 mask after set", 6'h04, 32'hFFFF_FFEF);
        pick_chk("R7 after masking bit 0");
    endtask

    task automatic t_priority();
        bus_write(6'h1C, 32'h0000_0080);
        mask_m[1] = 32'hFFFF_FF7F;
        bus_write(6'h2C, 32'h8000_0008);
        mask_m[2] = 32'h7FFF_FFF7;
        src[39] = 1'b1; src[95] = 1'b1; src[67] = 1'b1;
        pick_chk("R7 word2 wins");
        check("R7 word2 low bit value", {25'd0, nvec}, 32'd67);
        src[67] = 1'b0;
        pick_chk("R7 word2 bit31");
        src[95] = 1'b0;
        pick_chk("R7 fallback to word1");
        check("R7 word1 value", {25'd0, nvec}, 32'd39);
    endtask

    task automatic t_ignored();
        bus_write(6'h10, 32'hFFFF_FFFF);
        bus_write(6'h14, 32'hFFFF_FFFF);
        bus_write(6'h0E, 32'h0000_0010);
        bus_write(6'h3C, 32'hFFFF_FFFF);
        read_chk("R5 word1 mask kept", 6'h14, 32'hFFFF_FF7F);
        read_chk("R5 word0 mask kept", 6'h04, 32'hFFFF_FFEF);
        read_chk("R5 unmapped read", 6'h30, 32'h0);
        read_chk("R5 misaligned read", 6'h05, 32'h0);
    endtask

    task automatic t_irq_latency();
        @(negedge clk);
        check("R6 irq high before drop", {31'd0, irq}, 32'd1);
        src = '0;
        #1;
        check("R6 irq still high same cycle", {31'd0, irq}, 32'd1);
        pick_chk("R8 nothing pending");
        @(negedge clk);
        check("R6 irq low after edge", {31'd0, irq}, 32'd0);
    endtask

    task automatic id_chk(input logic [11:0] v, input int w, input int b);
        id = v;
        #1;
        check("R9 word", {30'd0, id_word}, 32'(w));
        check("R9 bit", {27'd0, id_bit}, 32'(b));
        check("R9 flat", {25'd0, id_flat}, 32'(32*w + b));
    endtask

    task automatic t_id();
        id_chk(12'h005, 0, 5);
        id_chk(12'h023, 1, 3);
        id_chk(12'h21F, 1, 31);
        id_chk(12'h0E2, 2, 2);
        id_chk(12'h400, 2, 0);
        id_chk(12'hA40, 2, 0);
        id_chk(12'h100, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status();
        t_clear_set();
        t_priority();
        t_ignored();
        t_irq_latency();
        t_id();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule